// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

This block is a general-purpose timer. A 32-bit count register advances once every time a 32-bit prescale counter finishes its programmed period. The prescaler runs on every clock cycle in timer mode. In counter mode it runs on synchronized edges of an external count input instead. Four match channels watch the count. Each can flag an interrupt, clear the count, halt it, and drive a dedicated output pin low, high or toggled. Channels 0 and 1 also emit a one-cycle DMA request strobe. Two capture channels snapshot the count on a chosen edge of their input pins.

Software reaches the block through a flat word-addressed write/read port. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. The address map is:

| Address | Register |
|---|---|
| 0 | control |
| 1 | prescale limit (PRE) |
| 2 | prescale count |
| 3 | main count |
| 4 | match control |
| 5 | output action |
| 6 | capture control |
| 7 | interrupt status |
| 8 to 11 | match values 0 to 3 |
| 12 to 13 | capture values 0 to 1 |

The control register holds the following fields:

| Bits | Field | Meaning |
|---|---|---|
| 0 | run enable | counting is allowed |
| 1 | synchronous clear | clears both counters |
| 3:2 | count source | clock or external edges |

A small state machine governs the counters. It has three states: IDLE (counters frozen), RUN (counting) and CLEAR (both counters forced to zero). It moves as follows:

| From | To | Condition |
|---|---|---|
| any | CLEAR | the clear bit is set |
| IDLE | RUN | the enable bit is set |
| RUN | IDLE | the enable bit is dropped, or a stop-on-match event occurs |
| CLEAR | RUN or IDLE | the clear bit is released; the enable bit selects which |

The state follows the control register one cycle later.

Top module: `prescaled_match_timer`

## Requirements
- R1: After reset every register reads zero and `match_out`, `dma_req` and `irq` are low.
- R2: In clock mode with the enable bit set, the prescale count (address 2) steps once per cycle from 0 up to PRE (address 1) and then wraps. At each wrap the main count (address 3) increases by one. Over T counted cycles the count therefore reaches floor(T/(PRE+1)) and the prescale count reaches T mod (PRE+1).
- R3: Control bits 3:2 select the count source. Code 0 selects the clock. Codes 1, 2 and 3 select rising, falling or both edges of `count_in`. In codes 1 to 3, each selected edge counts as one prescaler tick.
- R4: While control bit 1 is set, the prescale count and the main count are cleared and held at zero, even with the enable bit set.
- R5: A match event on channel i occurs when the prescaler wraps while the count equals match value i. With match-control bit 3i+1 set, that event reloads the count with zero instead of advancing it. A match value N therefore gives a period of (N+1)*(PRE+1) cycles in clock mode.
- R6: With match-control bit 3i+2 set, a match event on channel i leaves the count at the match value and clears control bit 0, so counting halts.
- R7: With match-control bit 3i set, a match event on channel i sets status bit i.
- R8: Output-action bits 2i+1:2i choose what a match event does to `match_out[i]`. Code 0 leaves it unchanged, code 1 drives it low, code 2 drives it high and code 3 inverts it.
- R9: Each match event on channel 0 or 1 produces a pulse on `dma_req[0]` or `dma_req[1]` one cycle after the event. The pulse is one cycle wide.
- R10: Capture-control bit 3j enables rising-edge capture and bit 3j+1 enables falling-edge capture for channel j, in any combination. On an enabled edge of the synchronized `cap_in[j]`, capture register j (address 12+j) takes the current count. An edge that is not enabled changes nothing.
- R11: With capture-control bit 3j+2 set, a capture on channel j also sets status bit 4+j. With the bit clear, the value is still captured but no flag is set.
- R12: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly when any status bit is set.
- R13: Writes to the prescale count, the main count and the capture registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| addr | input | 4 | register word address |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data for `addr` (combinational) |
| cap_in | input | 2 | capture inputs (asynchronous) |
| count_in | input | 1 | external count input (asynchronous) |
| match_out | output | 4 | match-driven output pins |
| dma_req | output | 2 | DMA request strobes from match channels 0 and 1 |
| irq | output | 1 | OR of the interrupt status bits |

## Verification
The bench measures the spacing of DMA strobes and of output toggles under reset-on-match. A design that reloaded one tick early or late would give a period of N or N+2 prescale periods instead of N+1. It drives stop-on-match and then reads the frozen count and the control register, which catches a count that slips past the match value and an enable bit that survives. Capture edges are tried one at a time with the other edge disabled, which exposes a design that captures on the wrong edge or flags an interrupt that was not enabled. The external count modes are each fed a known number of pulses, so counting both edges where one was asked for shows up as a doubled count. A wrong-bit write to the status register checks that the write-one-to-clear logic touches only the bits written as 1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CLR  = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } out_act_e;

    typedef enum logic [1:0] {
        SRC_CLK      = 2'd0,
        SRC_EXT_RISE = 2'd1,
        SRC_EXT_FALL = 2'd2,
        SRC_EXT_BOTH = 2'd3
    } cnt_src_e;

    localparam int AW = 4;

    localparam logic [AW-1:0] A_CTRL = 4'd0;
    localparam logic [AW-1:0] A_PRE  = 4'd1;
    localparam logic [AW-1:0] A_PCNT = 4'd2;
    localparam logic [AW-1:0] A_CNT  = 4'd3;
    localparam logic [AW-1:0] A_MCTL = 4'd4;
    localparam logic [AW-1:0] A_OACT = 4'd5;
    localparam logic [AW-1:0] A_CCTL = 4'd6;
    localparam logic [AW-1:0] A_STAT = 4'd7;
    localparam logic [AW-1:0] A_MR0  = 4'd8;
    localparam logic [AW-1:0] A_CAP0 = 4'd12;

    localparam int MAX_MATCH = 4;
    localparam int MAX_CAP   = 4;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1_q, s2_q, s3_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= raw[b];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end

        assign rise[b] = s2_q & ~s3_q;
        assign fall[b] = ~s2_q & s3_q;
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          srst,
    input  cnt_src_e      src,
    input  logic          ext_rise,
    input  logic          ext_fall,
    input  logic [CW-1:0] pr,
    input  logic          rst_req,
    input  logic          stop_req,
    output logic          adv,
    output logic [CW-1:0] tc,
    output logic [CW-1:0] pc
);

    cnt_state_e    state_q, state_d;
    logic [CW-1:0] tc_q, pc_q;
    logic          tick;

    always_comb begin
        unique case (src)
            SRC_CLK:      tick = 1'b1;
            SRC_EXT_RISE: tick = ext_rise;
            SRC_EXT_FALL: tick = ext_fall;
            SRC_EXT_BOTH: tick = ext_rise | ext_fall;
            default:      tick = 1'b0;
        endcase
    end

    assign adv = (state_q == ST_RUN) && tick && (pc_q >= pr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (srst) begin
            state_d = ST_CLR;
        end else begin
            unique case (state_q)
                ST_IDLE: if (en) state_d = ST_RUN;
                ST_RUN:  if (!en || (adv && stop_req)) state_d = ST_IDLE;
                ST_CLR:  state_d = en ? ST_RUN : ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // counters, per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q <= '0;
            pc_q <= '0;
        end else begin
            unique case (state_q)
                ST_CLR: begin
                    tc_q <= '0;
                    pc_q <= '0;
                end
                ST_RUN: begin
                    if (tick) begin
                        if (pc_q >= pr) begin
                            pc_q <= '0;
                            if (rst_req)       tc_q <= '0;
                            else if (!stop_req) tc_q <= tc_q + 1'b1;
                        end else begin
                            pc_q <= pc_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign tc = tc_q;
    assign pc = pc_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(tc_q) && $stable(pc_q))); // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLR) |=> (tc_q == '0 && pc_q == '0)); // R4
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && stop_req && !rst_req && !srst) |=> (state_q == ST_IDLE && $stable(tc_q))); // R6

endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [CW-1:0] tc,
    input  logic [CW-1:0] mr,
    input  out_act_e      act,
    output logic          evt,
    output logic          out
);

    logic out_q;

    assign evt = adv && (tc == mr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (evt) begin
            unique case (act)
                ACT_LOW:    out_q <= 1'b0;
                ACT_HIGH:   out_q <= 1'b1;
                ACT_TOGGLE: out_q <= ~out_q;
                default:    ;
            endcase
        end
    end

    assign out = out_q;

    AST_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && act == ACT_HIGH) |=> out_q); // R8
    AST_OUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && act == ACT_TOGGLE) |=> (out_q != $past(out_q))); // R8
    AST_OUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(out_q)); // R8

endmodule

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  logic          en_rise,
    input  logic          en_fall,
    input  logic [CW-1:0] tc,
    output logic          evt,
    output logic [CW-1:0] cap
);

    logic [CW-1:0] cap_q;

    assign evt = (rise && en_rise) || (fall && en_fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cap_q <= '0;
        else if (evt) cap_q <= tc;
    end

    assign cap = cap_q;

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cap_q)); // R10

endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
    import tmr_pkg::*;
#(
    parameter int CW     = 32,
    parameter int NMATCH = 4,
    parameter int NCAP   = 2,
    parameter int NDMA   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    input  logic [NCAP-1:0]   cap_in,
    input  logic              count_in,
    output logic [NMATCH-1:0] match_out,
    output logic [NDMA-1:0]   dma_req,
    output logic              irq
);

    localparam int SW  = NMATCH + NCAP;
    localparam int MCW = 3 * NMATCH;
    localparam int OAW = 2 * NMATCH;
    localparam int CCW = 3 * NCAP;

    // register file
    logic            ctrl_en, ctrl_srst;
    cnt_src_e        ctrl_src;
    logic [CW-1:0]   pr_q;
    logic [CW-1:0]   mr_q [NMATCH];
    logic [MCW-1:0]  mctl_q;
    logic [OAW-1:0]  oact_q;
    logic [CCW-1:0]  cctl_q;
    logic [SW-1:0]   stat_q;

    logic [NMATCH-1:0] m_evt, m_int, m_rst, m_stop;
    logic [NCAP-1:0]   c_evt, c_int, c_rise, c_fall;
    logic [CW-1:0]     cap_v [NCAP];
    logic              x_rise, x_fall;
    logic              adv, rst_req, stop_req;
    logic [CW-1:0]     tc, pc;
    logic [SW-1:0]     stat_set;
    logic [NDMA-1:0]   dma_q;
    logic              wr_ctrl, wr_stat;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);

    tmr_sync_edge #(.W(NCAP)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .raw(cap_in), .rise(c_rise), .fall(c_fall)
    );

    tmr_sync_edge #(.W(1)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .raw(count_in), .rise(x_rise), .fall(x_fall)
    );

    tmr_count_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .srst(ctrl_srst), .src(ctrl_src),
        .ext_rise(x_rise), .ext_fall(x_fall), .pr(pr_q),
        .rst_req(rst_req), .stop_req(stop_req), .adv(adv), .tc(tc), .pc(pc)
    );

    for (genvar i = 0; i < NMATCH; i++) begin : g_match
        assign m_int[i]  = mctl_q[3*i];
        assign m_rst[i]  = mctl_q[3*i+1];
        assign m_stop[i] = mctl_q[3*i+2];

        tmr_match_chan #(.CW(CW)) u_match (
            .clk(clk), .rst_n(rst_n), .adv(adv), .tc(tc), .mr(mr_q[i]),
            .act(out_act_e'(oact_q[2*i +: 2])), .evt(m_evt[i]), .out(match_out[i])
        );
    end

    for (genvar j = 0; j < NCAP; j++) begin : g_cap
        assign c_int[j] = cctl_q[3*j+2];

        tmr_cap_chan #(.CW(CW)) u_cap (
            .clk(clk), .rst_n(rst_n), .rise(c_rise[j]), .fall(c_fall[j]),
            .en_rise(cctl_q[3*j]), .en_fall(cctl_q[3*j+1]), .tc(tc),
            .evt(c_evt[j]), .cap(cap_v[j])
        );
    end

    assign rst_req  = |(m_evt & m_rst);
    assign stop_req = |(m_evt & m_stop);
    assign stat_set = {c_evt & c_int, m_evt & m_int};

    // control and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_srst <= 1'b0;
            ctrl_src  <= SRC_CLK;
            pr_q      <= '0;
            mctl_q    <= '0;
            oact_q    <= '0;
            cctl_q    <= '0;
            for (int i = 0; i < NMATCH; i++) mr_q[i] <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en   <= wdata[0];
                ctrl_srst <= wdata[1];
                ctrl_src  <= cnt_src_e'(wdata[3:2]);
            end
            if (stop_req) ctrl_en <= 1'b0;
            if (wr_en && addr == A_PRE)  pr_q   <= wdata;
            if (wr_en && addr == A_MCTL) mctl_q <= wdata[MCW-1:0];
            if (wr_en && addr == A_OACT) oact_q <= wdata[OAW-1:0];
            if (wr_en && addr == A_CCTL) cctl_q <= wdata[CCW-1:0];
            for (int i = 0; i < NMATCH; i++) begin
                if (wr_en && addr == AW'(int'(A_MR0) + i)) mr_q[i] <= wdata;
            end
        end
    end

    // interrupt status, write one to clear, new events win
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~(wr_stat ? wdata[SW-1:0] : '0)) | stat_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dma_q <= '0;
        else        dma_q <= m_evt[NDMA-1:0];
    end

    assign dma_req = dma_q;
    assign irq     = |stat_q;

    // read port
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = CW'({ctrl_src, ctrl_srst, ctrl_en});
            A_PRE:   rdata = pr_q;
            A_PCNT:  rdata = pc;
            A_CNT:   rdata = tc;
            A_MCTL:  rdata = CW'(mctl_q);
            A_OACT:  rdata = CW'(oact_q);
            A_CCTL:  rdata = CW'(cctl_q);
            A_STAT:  rdata = CW'(stat_q);
            default: begin
                for (int i = 0; i < NMATCH; i++)
                    if (addr == AW'(int'(A_MR0) + i)) rdata = mr_q[i];
                for (int j = 0; j < NCAP; j++)
                    if (addr == AW'(int'(A_CAP0) + j)) rdata = cap_v[j];
            end
        endcase
    end

    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !ctrl_en); // R6
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_q & $past(wdata[SW-1:0]) & ~$past(stat_set)) == '0)); // R12
    AST_CFG_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        (NMATCH <= MAX_MATCH && NCAP <= MAX_CAP && NDMA <= NMATCH)); // R1

endmodule

// File: tb/prescaled_match_timer_tb.sv
`timescale 1ns/1ps
module prescaled_match_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  cap_in = '0;
    logic        count_in = 1'b0;
    logic [3:0]  match_out;
    logic [1:0]  dma_req;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int q_dma[$];
    int q_tog[$];
    int last_dma = 0, last_tog = 0;
    bit dma_valid = 0, tog_valid = 0;
    bit prev_d0 = 0, prev_m2 = 0;
    int n_dma1 = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prescaled_match_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .count_in(count_in),
        .match_out(match_out), .dma_req(dma_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            count_in = 1'b1; idle(3);
            count_in = 1'b0; idle(3);
        end
    endtask

    // scoreboard driver side: expected gaps between DMA strobes and output toggles
    task automatic expect_gaps(input int n, input int gap);
        dma_valid = 0;
        tog_valid = 0;
        for (int k = 0; k < n; k++) begin
            q_dma.push_back(gap);
            q_tog.push_back(gap);
        end
    endtask

    // monitor side
    always @(negedge clk) begin
        cyc++;
        if (dma_req[0]) begin
            if (prev_d0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 strobe width: got 2+ cycles expected 1");
            end
            if (dma_valid && q_dma.size() > 0) chk("R5 R9 strobe period", cyc - last_dma, q_dma.pop_front());
            last_dma = cyc;
            dma_valid = 1;
        end
        if (match_out[2] != prev_m2) begin
            if (tog_valid && q_tog.size() > 0) chk("R8 toggle period", cyc - last_tog, q_tog.pop_front());
            last_tog = cyc;
            tog_valid = 1;
        end
        if (dma_req[1]) n_dma1++;
        prev_d0 = dma_req[0];
        prev_m2 = match_out[2];
    end

    initial begin : main
        logic [31:0] v;
        bit m2;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(4'd0, v);  chk("R1 ctrl", v, 0);
        rd(4'd3, v);  chk("R1 count", v, 0);
        rd(4'd7, v);  chk("R1 status", v, 0);
        rd(4'd8, v);  chk("R1 match0", v, 0);
        chk("R1 outputs", {match_out, dma_req, irq}, 0);

        // R13 read-only registers
        wr(4'd3, 32'h55);  rd(4'd3, v);  chk("R13 count write", v, 0);
        wr(4'd2, 32'h7);   rd(4'd2, v);  chk("R13 pcount write", v, 0);
        wr(4'd12, 32'h99); rd(4'd12, v); chk("R13 capture write", v, 0);

        // R2 prescaler: PRE=3, 38 counted cycles
        wr(4'd1, 3);
        wr(4'd0, 1);
        idle(37);
        wr(4'd0, 0);
        idle(3);
        rd(4'd3, v); chk("R2 count", v, 9);
        rd(4'd2, v); chk("R2 pcount", v, 2);

        // R4 synchronous clear held even with enable
        wr(4'd0, 3);
        idle(6);
        rd(4'd3, v); chk("R4 count held", v, 0);
        rd(4'd2, v); chk("R4 pcount held", v, 0);
        wr(4'd0, 0);

        // R5 R8 R9 reset-on-match period, toggle and set-high actions
        wr(4'd1, 1);
        wr(4'd8, 4);
        wr(4'd10, 1);
        wr(4'd11, 2);
        wr(4'd4, 32'h2);
        wr(4'd5, 32'hB0);
        expect_gaps(3, 10);
        wr(4'd0, 1);
        idle(70);
        chk("R5 scoreboard drained", q_dma.size(), 0);
        chk("R8 toggle scoreboard drained", q_tog.size(), 0);
        chk("R8 set high", match_out[3], 1);
        wr(4'd5, 32'h40);
        idle(1);
        m2 = match_out[2];
        idle(30);
        chk("R8 set low", match_out[3], 0);
        chk("R8 no action", match_out[2], m2);
        wr(4'd0, 0);
        q_dma.delete();
        q_tog.delete();

        // R6 R7 R9 stop-on-match with interrupt on channel 1
        wr(4'd5, 0);
        wr(4'd1, 0);
        wr(4'd9, 6);
        wr(4'd4, 32'h28);
        wr(4'd0, 2);
        n_dma1 = 0;
        wr(4'd0, 1);
        idle(20);
        rd(4'd3, v); chk("R6 count frozen", v, 6);
        rd(4'd0, v); chk("R6 enable cleared", v, 0);
        rd(4'd7, v); chk("R7 status bit", v, 2);
        chk("R12 irq high", irq, 1);
        chk("R9 channel 1 strobes", n_dma1, 1);
        wr(4'd7, 1);
        rd(4'd7, v); chk("R12 wrong bit keeps", v, 2);
        wr(4'd7, 2);
        rd(4'd7, v); chk("R12 cleared", v, 0);
        chk("R12 irq low", irq, 0);

        // R10 R11 capture edges with counter frozen at 6
        wr(4'd6, 32'h35);
        cap_in[0] = 1'b1; idle(5);
        rd(4'd12, v); chk("R10 rising capture", v, 6);
        rd(4'd7, v);  chk("R11 capture flag", v, 32'h10);
        wr(4'd7, 32'h10);
        cap_in[0] = 1'b0; idle(5);
        rd(4'd7, v);  chk("R10 falling ignored", v, 0);
        cap_in[1] = 1'b1; idle(5);
        rd(4'd7, v);  chk("R10 rising ignored ch1", v, 0);
        rd(4'd13, v); chk("R10 ch1 unchanged", v, 0);
        cap_in[1] = 1'b0; idle(5);
        rd(4'd13, v); chk("R10 falling capture ch1", v, 6);
        rd(4'd7, v);  chk("R11 ch1 flag", v, 32'h20);
        wr(4'd7, 32'h20);
        wr(4'd0, 2);
        wr(4'd0, 0);
        wr(4'd6, 32'h3);
        cap_in[0] = 1'b1; idle(5);
        rd(4'd12, v); chk("R10 capture after clear", v, 0);
        rd(4'd7, v);  chk("R11 no flag when disabled", v, 0);
        wr(4'd6, 32'h7);
        cap_in[0] = 1'b0; idle(5);
        rd(4'd7, v);  chk("R10 both-edge falling", v, 32'h10);
        wr(4'd7, 32'h10);

        // R3 external count sources
        wr(4'd4, 0);
        wr(4'd0, 2); wr(4'd0, 5); idle(3);
        pulses(5); idle(5);
        rd(4'd3, v); chk("R3 rising edges", v, 5);
        wr(4'd0, 2); wr(4'd0, 13); idle(3);
        pulses(4); idle(5);
        rd(4'd3, v); chk("R3 both edges", v, 8);
        wr(4'd0, 2); wr(4'd0, 9); idle(3);
        pulses(3); idle(5);
        rd(4'd3, v); chk("R3 falling edges", v, 3);
        wr(4'd0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule